// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a key matrix. It drives row-select lines, samples active-low column inputs that have pull-ups, and stores one 16-bit word per row. A key that is pressed reads as 0 in its column bit. Software controls the block through a small register bus that follows the APB style. One control word selects the scan mode, the settle time per row and the pause between scans. A second word sets how many rows and how many columns take part in a scan.

There are four modes: idle, any-key detect, one-shot scan and repeating scan. The one-shot scan clears its own mode field when it finishes. The repeating scan pauses after each pass and then starts again. Any-key detect drives every row at once and leaves the stored words untouched. It raises a status flag that stays set for as long as a key is held down.

Three status events are tracked: scan finished, stored data changed, and key seen in detect mode. Each is cleared by writing a one to it. A mask selects which events reach the single interrupt line.

Top module: `keyscan_top`

## Requirements
- R1: After reset every register reads zero, rowDrive is zero and irq is low.
- R2: Writing mode 2 to control bits 1:0 (offset 0x00) runs one scan over the rows. The mode field then returns to 0 and status bit 0 sets. Row r is stored in the halfword at byte offset 0x10+2r: the even row is in the low half of each 32-bit word. A pressed key stores 0 in its column bit.
- R3: During a scan each row is driven alone for exactly rowDelay+1 cycles before it is sampled. rowDelay is control bits 15:2.
- R4: In mode 3 each finished scan is followed by scanDelay+1 cycles with no row driven. scanDelay is control bits 31:16. A new scan then starts by itself and refreshes the stored words.
- R5: Rows whose index is at or above the row count are not refreshed and keep their old words. The row count is bits 7:0 at offset 0x04.
- R6: In a refreshed row, column bits at or above the column count store 1. The column count is bits 15:8 at offset 0x04.
- R7: Status bit 1 sets at the end of a scan only if some refreshed word differs from its previous value.
- R8: In mode 1 no stored word changes. Status bit 2 sets while any column below the column count reads low. Writing 1 to clear bit 2 has no effect while such a key is held. Columns at or above the column count are ignored.
- R9: Writing 1 to a bit of the status word (offset 0x08) clears that bit. Writing 0 leaves it unchanged.
- R10: irq is high exactly when some status bit and the matching mask bit (offset 0x0C, bits 2:0) are both 1.
- R11: rowDrive has at most one bit set in modes 0, 2 and 3. It is all ones in mode 1.
- R12: Writing mode 0 during a repeating scan stops row driving from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus select |
| busEnable | input | 1 | Bus access phase |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W (8) | Byte address; only word-aligned addresses decode |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, driven combinationally from busAddr |
| colIn | input | 16 | Column inputs, active low |
| rowDrive | output | 16 | Row select, active high |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default sizes: 16 rows, 16 columns and an 8-bit address. It programs row counts and column counts below those maxima, which brings both stale rows and forced-one columns into play. Settle times of one and two cycles and a pause of five cycles keep the row-by-row drive and the pause measurable cycle by cycle. A behavioural key matrix answers the row drive, so the stored patterns show the row selection and the column masking.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int KS_ROWS       = 16;
  localparam int KS_COLS       = 16;
  localparam int KS_ROW_W      = $clog2(KS_ROWS);
  localparam int KS_CNT_W      = 8;
  localparam int KS_DATA_W     = 32;
  localparam int KS_DLY_ROW_W  = 14;
  localparam int KS_DLY_SCAN_W = 16;
  localparam int KS_IRQ_N      = 3;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_DETECT = 2'd1,
    MODE_ONCE   = 2'd2,
    MODE_LOOP   = 2'd3
  } scanMode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_GAP    = 2'd2
  } scanState_e;

  typedef struct packed {
    logic                startScan;
    logic                rowWrite;
    logic                doneScan;
    logic                clearMode;
    logic [KS_ROW_W-1:0] rowIdx;
  } scanStrobe_t;
endpackage

// File: rtl/keyscan_seq.sv
module keyscan_seq
  import keyscan_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  scanMode_e                mode,
  input  logic [KS_DLY_ROW_W-1:0]  rowDelay,
  input  logic [KS_DLY_SCAN_W-1:0] scanDelay,
  input  logic [KS_CNT_W-1:0]      rowCount,
  output scanStrobe_t              strobe,
  output logic [KS_ROWS-1:0]       rowDrive
);
  scanState_e                 state, nState;
  logic [KS_ROW_W-1:0]        rowIdx, nRow;
  logic [KS_DLY_SCAN_W-1:0]   waitCnt, nCnt;
  logic                       scanning, lastRow, rowDone, gapDone;

  assign scanning = (mode == MODE_ONCE) || (mode == MODE_LOOP);
  assign lastRow  = ((KS_CNT_W'(rowIdx) + KS_CNT_W'(1)) >= rowCount) ||
                    (rowIdx == KS_ROW_W'(KS_ROWS - 1));
  assign rowDone  = waitCnt == KS_DLY_SCAN_W'(rowDelay);
  assign gapDone  = waitCnt == scanDelay;

  always_comb begin
    strobe        = '0;
    strobe.rowIdx = rowIdx;
    nState        = state;
    nRow          = rowIdx;
    nCnt          = waitCnt + KS_DLY_SCAN_W'(1);
    case (state)
      ST_IDLE: begin
        nCnt = '0;
        if (scanning) begin
          strobe.startScan = 1'b1;
          nState           = ST_SETTLE;
          nRow             = '0;
        end
      end
      ST_SETTLE: begin
        if (!scanning) begin
          nState = ST_IDLE;
          nCnt   = '0;
        end else if (rowDone) begin
          strobe.rowWrite = 1'b1;
          nCnt            = '0;
          if (lastRow) begin
            strobe.doneScan = 1'b1;
            if (mode == MODE_ONCE) begin
              strobe.clearMode = 1'b1;
              nState           = ST_IDLE;
            end else begin
              nState = ST_GAP;
            end
          end else begin
            nRow = rowIdx + KS_ROW_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (!scanning) begin
          nState = ST_IDLE;
          nCnt   = '0;
        end else if (gapDone) begin
          strobe.startScan = 1'b1;
          nState           = ST_SETTLE;
          nRow             = '0;
          nCnt             = '0;
        end
      end
      default: begin
        nState = ST_IDLE;
        nCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rowIdx  <= '0;
      waitCnt <= '0;
    end else begin
      state   <= nState;
      rowIdx  <= nRow;
      waitCnt <= nCnt;
    end
  end

  always_comb begin
    if (mode == MODE_DETECT)    rowDrive = '1;
    else if (state == ST_SETTLE) rowDrive = KS_ROWS'(1) << rowIdx;
    else                         rowDrive = '0;
  end
endmodule

// File: rtl/keyscan_regs.sv
module keyscan_regs
  import keyscan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busWrEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [KS_DATA_W-1:0]     busWdata,
  output logic [KS_DATA_W-1:0]     busRdata,
  input  logic [KS_COLS-1:0]       colIn,
  input  scanStrobe_t              strobe,
  output scanMode_e                mode,
  output logic [KS_DLY_ROW_W-1:0]  rowDelay,
  output logic [KS_DLY_SCAN_W-1:0] scanDelay,
  output logic [KS_CNT_W-1:0]      rowCount,
  output logic [KS_DATA_W-1:0]     ctrlWord,
  output logic [2*KS_CNT_W-1:0]    cfgWord,
  output logic [KS_IRQ_N-1:0]      statusBits,
  output logic [KS_IRQ_N-1:0]      maskBits,
  output logic                     irq
);
  localparam int WORD_IDX_W   = ADDR_W - 2;
  localparam int REG_CTRL     = 0;
  localparam int REG_CFG      = 1;
  localparam int REG_STATUS   = 2;
  localparam int REG_MASK     = 3;
  localparam int ROW_REG_BASE = 4;
  localparam int PAIR_N       = KS_ROWS / 2;

  logic [WORD_IDX_W-1:0] regIdx, pairOff;
  logic                  aligned, isRow;
  logic                  wrCtrl, wrCfg, wrStatus, wrMask;
  logic [KS_CNT_W-1:0]   colCount;
  logic [KS_COLS-1:0]    colMask, sampleWord;
  logic [KS_COLS-1:0]    rowData [KS_ROWS];
  logic [KS_DATA_W-1:0]  pairWord [PAIR_N];
  logic                  rowInRange, rowDiff, scanChanged, keyDown;
  logic [KS_IRQ_N-1:0]   setBits, ackBits;

  assign regIdx   = busAddr[ADDR_W-1:2];
  assign aligned  = busAddr[1:0] == 2'b00;
  assign pairOff  = regIdx - WORD_IDX_W'(ROW_REG_BASE);
  assign isRow    = (regIdx >= WORD_IDX_W'(ROW_REG_BASE)) && (pairOff < WORD_IDX_W'(PAIR_N));
  assign wrCtrl   = busWrEn && aligned && (regIdx == WORD_IDX_W'(REG_CTRL));
  assign wrCfg    = busWrEn && aligned && (regIdx == WORD_IDX_W'(REG_CFG));
  assign wrStatus = busWrEn && aligned && (regIdx == WORD_IDX_W'(REG_STATUS));
  assign wrMask   = busWrEn && aligned && (regIdx == WORD_IDX_W'(REG_MASK));

  assign mode      = scanMode_e'(ctrlWord[1:0]);
  assign rowDelay  = ctrlWord[2 +: KS_DLY_ROW_W];
  assign scanDelay = ctrlWord[KS_DATA_W-1 -: KS_DLY_SCAN_W];
  assign rowCount  = cfgWord[KS_CNT_W-1:0];
  assign colCount  = cfgWord[2*KS_CNT_W-1:KS_CNT_W];

  for (genvar c = 0; c < KS_COLS; c++) begin : g_colMask
    assign colMask[c] = KS_CNT_W'(c) < colCount;
  end
  for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
    assign pairWord[p] = KS_DATA_W'({rowData[2*p+1], rowData[2*p]});
  end

  assign sampleWord = colIn | ~colMask;
  assign keyDown    = (mode == MODE_DETECT) && (sampleWord != '1);
  assign rowInRange = KS_CNT_W'(strobe.rowIdx) < rowCount;
  assign rowDiff    = rowInRange && (rowData[strobe.rowIdx] != sampleWord);

  assign setBits = {keyDown,
                    strobe.doneScan && (scanChanged || (strobe.rowWrite && rowDiff)),
                    strobe.doneScan};
  assign ackBits = wrStatus ? (busWdata[KS_IRQ_N-1:0] & {~keyDown, {(KS_IRQ_N-1){1'b1}}})
                            : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlWord    <= '0;
      cfgWord     <= '0;
      statusBits  <= '0;
      maskBits    <= '0;
      scanChanged <= 1'b0;
      for (int r = 0; r < KS_ROWS; r++) rowData[r] <= '0;
    end else begin
      if (wrCtrl)                ctrlWord      <= busWdata;
      else if (strobe.clearMode) ctrlWord[1:0] <= MODE_IDLE;
      if (wrCfg)  cfgWord  <= busWdata[2*KS_CNT_W-1:0];
      if (wrMask) maskBits <= busWdata[KS_IRQ_N-1:0];
      statusBits <= (statusBits & ~ackBits) | setBits;
      if (strobe.startScan)                scanChanged <= 1'b0;
      else if (strobe.rowWrite && rowDiff) scanChanged <= 1'b1;
      if (strobe.rowWrite && rowInRange) rowData[strobe.rowIdx] <= sampleWord;
    end
  end

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      if (isRow) busRdata = pairWord[pairOff[KS_ROW_W-2:0]];
      else if (regIdx == WORD_IDX_W'(REG_CTRL))   busRdata = ctrlWord;
      else if (regIdx == WORD_IDX_W'(REG_CFG))    busRdata = KS_DATA_W'(cfgWord);
      else if (regIdx == WORD_IDX_W'(REG_STATUS)) busRdata = KS_DATA_W'(statusBits);
      else if (regIdx == WORD_IDX_W'(REG_MASK))   busRdata = KS_DATA_W'(maskBits);
    end
  end

  assign irq = |(statusBits & maskBits);
endmodule

// File: rtl/keyscan_top.sv
module keyscan_top
  import keyscan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busSel,
  input  logic                 busEnable,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [KS_DATA_W-1:0] busWdata,
  output logic [KS_DATA_W-1:0] busRdata,
  input  logic [KS_COLS-1:0]   colIn,
  output logic [KS_ROWS-1:0]   rowDrive,
  output logic                 irq
);
  scanStrobe_t              strobe;
  scanMode_e                mode;
  logic [KS_DLY_ROW_W-1:0]  rowDelay;
  logic [KS_DLY_SCAN_W-1:0] scanDelay;
  logic [KS_CNT_W-1:0]      rowCount;
  logic [KS_DATA_W-1:0]     ctrlWord;
  logic [2*KS_CNT_W-1:0]    cfgWord;
  logic [KS_IRQ_N-1:0]      statusBits, maskBits;
  logic                     busWrEn;

  assign busWrEn = busSel && busEnable && busWrite;

  keyscan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .colIn(colIn), .strobe(strobe),
    .mode(mode), .rowDelay(rowDelay), .scanDelay(scanDelay), .rowCount(rowCount),
    .ctrlWord(ctrlWord), .cfgWord(cfgWord), .statusBits(statusBits),
    .maskBits(maskBits), .irq(irq)
  );

  keyscan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rowDelay(rowDelay),
    .scanDelay(scanDelay), .rowCount(rowCount), .strobe(strobe), .rowDrive(rowDrive)
  );
endmodule

// File: rtl/keyscan_checker.sv
module keyscan_checker
  import keyscan_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busSel,
  input logic                  busEnable,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [KS_COLS-1:0]    colIn,
  input logic [KS_ROWS-1:0]    rowDrive,
  input logic                  irq,
  input logic [KS_DATA_W-1:0]  ctrlWord,
  input logic [2*KS_CNT_W-1:0] cfgWord,
  input logic [KS_IRQ_N-1:0]   statusBits,
  input logic [KS_IRQ_N-1:0]   maskBits
);
  logic [1:0]         modeNow;
  logic               ctrlWrite, keyHeld;
  logic [KS_COLS-1:0] activeLow;

  assign modeNow   = ctrlWord[1:0];
  assign ctrlWrite = busSel && busEnable && busWrite && (busAddr == '0);

  always_comb begin
    for (int c = 0; c < KS_COLS; c++)
      activeLow[c] = (c < int'(cfgWord[2*KS_CNT_W-1:KS_CNT_W])) && !colIn[c];
    keyHeld = |activeLow;
  end

  // R11: a single row at a time outside detect mode
  a_r11_drive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (modeNow != 2'd1) |-> $onehot0(rowDrive));

  // R10: the interrupt only rises with an enabled pending event
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> |(statusBits & maskBits));

  // R10: a fully masked block stays quiet
  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (maskBits == '0) |-> !irq);

  // R8: a held key in detect mode keeps bit 2 set
  a_r8_hold_pressed: assert property (@(posedge clk) disable iff (!rst_n)
    (modeNow == 2'd1 && keyHeld) |=> statusBits[2]);

  // R2: the end of a one-shot scan clears the mode field
  a_r2_once_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(|rowDrive) && $past(modeNow) == 2'd2 && !$past(ctrlWrite)) |-> modeNow == 2'd0);

  // R12: idle mode held over a cycle means no row is driven
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (modeNow == 2'd0 && $past(modeNow) == 2'd0) |-> rowDrive == '0);
endmodule

bind keyscan_top keyscan_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .busEnable(busEnable),
  .busWrite(busWrite), .busAddr(busAddr), .colIn(colIn), .rowDrive(rowDrive),
  .irq(irq), .ctrlWord(ctrlWord), .cfgWord(cfgWord), .statusBits(statusBits),
  .maskBits(maskBits)
);

// File: tb/keyscan_top_test.sv
module keyscan_top_test;
  import keyscan_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0]    busAddr = '0;
  logic [KS_DATA_W-1:0] busWdata = '0;
  logic [KS_DATA_W-1:0] busRdata;
  logic [KS_COLS-1:0]   colIn;
  logic [KS_ROWS-1:0]   rowDrive;
  logic                 irq;
  logic [KS_COLS-1:0]   keyMap [KS_ROWS];

  int checks = 0, failures = 0;
  bit finished = 0;

  keyscan_top #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .colIn(colIn), .rowDrive(rowDrive), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < KS_COLS; c++) begin
      colIn[c] = 1'b1;
      for (int r = 0; r < KS_ROWS; r++)
        if (rowDrive[r] && keyMap[r][c]) colIn[c] = 1'b0;
    end
  end

  int  drvCount [KS_ROWS];
  int  nonZero, zeroRun, lastGap, badDrive = 0;
  bit  seenDrive, monClear = 0;

  always @(negedge clk) begin
    if (monClear) begin
      for (int r = 0; r < KS_ROWS; r++) drvCount[r] = 0;
      nonZero = 0; zeroRun = 0; lastGap = -1; seenDrive = 0;
    end else begin
      if (rowDrive == '0) zeroRun++;
      else begin
        nonZero++;
        if (seenDrive && zeroRun > 0) lastGap = zeroRun;
        zeroRun = 0;
        seenDrive = 1;
      end
      for (int r = 0; r < KS_ROWS; r++)
        if (rowDrive == (KS_ROWS'(1) << r)) drvCount[r]++;
      if (!$onehot0(rowDrive) && rowDrive != '1) badDrive++;
    end
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; busEnable = 0;
    @(negedge clk);
    busEnable = 1;
    @(negedge clk);
    busSel = 0; busEnable = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a; busEnable = 0;
    @(negedge clk);
    busEnable = 1;
    #1 d = busRdata;
    busSel = 0; busEnable = 0;
  endtask

  task automatic monReset();
    monClear = 1;
    @(negedge clk);
    @(posedge clk);
    monClear = 0;
  endtask

  task automatic clearKeys();
    for (int r = 0; r < KS_ROWS; r++) keyMap[r] = '0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < 500 && !s[0]; i++) busRd(8'h08, s);
  endtask

  task automatic runOnce(input logic [13:0] dly);
    monReset();
    busWr(8'h00, {16'd0, dly, 2'd2});
    waitDone();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    checkEq("R1 rowDrive", 32'(rowDrive), 0);
    checkEq("R1 irq", 32'(irq), 0);
    for (int a = 0; a < 12; a++) begin
      busRd(8'(a * 4), d);
      checkEq("R1 register", d, 0);
    end
  endtask

  task automatic t_single();
    logic [31:0] d;
    clearKeys();
    keyMap[0][0] = 1; keyMap[1][3] = 1; keyMap[1][4] = 1; keyMap[3][1] = 1;
    busWr(8'h04, 32'h0000_1003);
    runOnce(14'd2);
    busRd(8'h10, d); checkEq("R2 rows 0 and 1", d, 32'hFFE7_FFFE);
    busRd(8'h14, d); checkEq("R5 row 3 stale, row 2 idle", d, 32'h0000_FFFF);
    busRd(8'h00, d); checkEq("R2 mode returns to 0", d, 32'h0000_0008);
    busRd(8'h08, d); checkEq("R7 done and changed", d, 3);
    for (int r = 0; r < 4; r++)
      checkEq("R3 settle cycles per row", drvCount[r], (r < 3) ? 3 : 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    busWr(8'h08, 32'h2);
    busRd(8'h08, d); checkEq("R9 clear bit 1 only", d, 1);
    busWr(8'h08, 32'h1);
    busRd(8'h08, d); checkEq("R9 clear bit 0", d, 0);
  endtask

  task automatic t_unchanged();
    logic [31:0] d;
    runOnce(14'd2);
    busRd(8'h08, d); checkEq("R7 same data, no change flag", d, 1);
    busWr(8'h08, 32'h7);
  endtask

  task automatic t_rowsCols();
    logic [31:0] d;
    clearKeys();
    keyMap[0][0] = 1; keyMap[0][6] = 1; keyMap[1][4] = 1; keyMap[1][9] = 1; keyMap[2][0] = 1;
    busWr(8'h04, 32'h0000_0502);
    runOnce(14'd1);
    busRd(8'h10, d); checkEq("R6 columns beyond count read 1", d, 32'hFFEF_FFFE);
    busRd(8'h14, d); checkEq("R5 row 2 keeps old word", d, 32'h0000_FFFF);
    busRd(8'h08, d); checkEq("R7 row 1 changed", d, 3);
    busWr(8'h08, 32'h7);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    busWr(8'h0C, 32'h1);
    checkEq("R10 no pending event", 32'(irq), 0);
    runOnce(14'd1);
    busRd(8'h08, d);
    checkEq("R10 done with mask set", 32'(irq), 1);
    busWr(8'h0C, 32'h6);
    checkEq("R10 done masked off", 32'(irq), 0);
    busWr(8'h0C, 32'h0);
    busWr(8'h08, 32'h7);
  endtask

  task automatic t_continuous();
    logic [31:0] d;
    clearKeys();
    keyMap[1][15] = 1;
    busWr(8'h04, 32'h0000_1002);
    monReset();
    busWr(8'h00, 32'h0005_0007);
    repeat (100) @(negedge clk);
    checkEq("R4 pause cycles", lastGap, 6);
    keyMap[0][8] = 1;
    repeat (40) @(negedge clk);
    busRd(8'h10, d); checkEq("R4 rescan refreshes data", d, 32'h7FFF_FEFF);
    busWr(8'h00, 32'h0);
    monReset();
    repeat (20) @(negedge clk);
    checkEq("R12 no drive after stop", nonZero, 0);
    busRd(8'h00, d); checkEq("R12 mode reads 0", d, 0);
  endtask

  task automatic t_detect();
    logic [31:0] d, snap;
    busWr(8'h08, 32'h7);
    clearKeys();
    busWr(8'h04, 32'h0000_0502);
    busRd(8'h10, snap);
    busWr(8'h00, 32'h1);
    @(negedge clk);
    checkEq("R11 all rows in detect", 32'(rowDrive), 32'h0000_FFFF);
    busRd(8'h08, d); checkEq("R8 no key, no flag", d, 0);
    keyMap[3][2] = 1;
    repeat (2) @(negedge clk);
    busRd(8'h08, d); checkEq("R8 key sets bit 2", d, 4);
    busWr(8'h08, 32'h4);
    busRd(8'h08, d); checkEq("R8 ack ignored while held", d, 4);
    clearKeys();
    keyMap[0][7] = 1;
    busWr(8'h08, 32'h4);
    busRd(8'h08, d); checkEq("R8 masked column ignored, ack clears", d, 0);
    busRd(8'h10, d); checkEq("R8 data untouched", d, snap);
    busWr(8'h00, 32'h0);
    clearKeys();
    checkEq("R11 no illegal drive pattern", badDrive, 0);
  endtask

  initial begin
    clearKeys();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_w1c();
    t_unchanged();
    t_rowsCols();
    t_irq();
    t_continuous();
    t_detect();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule